// File: doc/BRIEF.md
# Circular Buffer Data Address Generator

This block generates data-memory addresses for a signal-processing datapath. It holds four register sets, and each set has an index, a modify step and a buffer length, all 14 bits wide. On an access, the selected index appears at once on the address output. In the same cycle the index is advanced by a modify value, which may come from a different set, and wraps inside a circular buffer. The buffer's base is not stored. It is found by clearing the low bits of the index, because the length fixes how many low bits that is.

A separate reverse control mirrors all 14 bits of the output address. FFT code uses this to walk data in bit-reversed order. The value stored back into the index register always stays in normal bit order. Loading the modify register with 2^(14−N) makes the upper N bits of the index count, so the reversed output sweeps an N-bit range. A length of zero turns off wrapping and gives a plain 14-bit step.

Top module: `cbuf_dag`

## Requirements
- R1: After reset every index, modify and length register of every set is zero, so the address output reads 0 for any selected set.
- R2: With reverse off, the address output shows, in the same cycle, the current index of the set named by the index-set select. This is true whether or not an access is requested.
- R3: With a nonzero length L, let n be the smallest value with 2^n ≥ L and let B be the index with its low n bits cleared. An access then stores B + ((I + M − B) mod L) into the index of the index set, where L is that set's length. Examples: L=3, M=1 from 5 gives 5,6,4,5. L=5, M=3 from 9 gives 9,12,10,8,11,9. Inputs are restricted to |M| ≤ L with the start inside the buffer.
- R4: The modify value is 14-bit two's complement (0x3FFF is −1), and negative steps wrap downward. For example, L=3, M=−1 from 5 gives 5,4,6,5.
- R5: A length of zero makes the update I + M modulo 2^14.
- R6: The modify value is taken from the set named by the modify-set select, which may differ from the index-set select. The length always comes from the index set.
- R7: With reverse on, output bit k equals bit 13−k of the selected index. The stored index is still updated in normal order, so turning reverse off shows the plain value.
- R8: Writes use a kind code on the write-kind input: 0 index, 1 modify, 2 length. Code 3 changes nothing. Only the addressed register of the set on the write-set select is written.
- R9: A register write and an access to the same index register in the same cycle leave the written value in that register. An index write to a different set in that cycle does not block the access update.
- R10: Without an access or a write, the indices keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 0 index, 1 modify, 2 length, 3 none |
| wr_set | input | 2 | Register set addressed by the write |
| wr_data | input | 14 | Write value |
| acc_en | input | 1 | Access request: post-modify the selected index |
| acc_iset | input | 2 | Set supplying index and length |
| acc_mset | input | 2 | Set supplying the modify value |
| rev_mode | input | 1 | Mirror all 14 output address bits |
| addr_out | output | 14 | Address (current index, possibly mirrored) |

## Verification
A register write and an access can land in the same cycle on the same index register. In that case the write must win over the computed post-modify value. The bench starts an access on a set and writes a different index into that same set in the same cycle, then reads the set back and expects the written value. It also repeats this with the write aimed at another set and expects both the written value and the advanced index. The other overlap is reverse mode with an update: the bench steps the index with reverse on and judges the mirrored output and the normal-order readback after turning reverse off. Expected addresses across all lengths 1..16, all steps −L..L and all start offsets come from plain modulo arithmetic in the bench.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
    typedef enum logic [1:0] {
        KIND_INDEX  = 2'b00,
        KIND_MODIFY = 2'b01,
        KIND_LENGTH = 2'b10,
        KIND_NONE   = 2'b11
    } reg_kind_e;
endpackage

// File: rtl/cbuf_span_mask.sv
// Mask of the low bits that address inside a buffer of length len:
// bit b is set when len-1 has any set bit at or above b.
module cbuf_span_mask #(
    parameter int AW = 14
) (
    input  logic [AW-1:0] len,
    output logic [AW-1:0] mask
);
    logic [AW-1:0] len_m1;
    assign len_m1 = len - 1'b1;

    for (genvar b = 0; b < AW; b++) begin : g_bit
        assign mask[b] = |(len_m1 >> b);
    end
endmodule

// File: rtl/cbuf_wrap_step.sv
// Next index for a post-modify access, circular when len != 0.
module cbuf_wrap_step #(
    parameter int AW = 14
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] mod,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt
);
    localparam int SW = AW + 2;

    logic [AW-1:0]        mask;
    logic [AW-1:0]        base;
    logic signed [SW-1:0] off_s;
    logic signed [SW-1:0] mod_s;
    logic signed [SW-1:0] len_s;
    logic signed [SW-1:0] sum_s;

    cbuf_span_mask #(.AW(AW)) u_mask (
        .len  (len),
        .mask (mask)
    );

    always_comb begin
        base  = idx & ~mask;
        off_s = $signed({2'b00, idx & mask});
        mod_s = $signed({{2{mod[AW-1]}}, mod});
        len_s = $signed({2'b00, len});
        sum_s = off_s + mod_s;
        if (len == '0) begin
            nxt = idx + mod;
        end else if (sum_s < 0) begin
            nxt = base | AW'(sum_s + len_s);
        end else if (sum_s >= len_s) begin
            nxt = base | AW'(sum_s - len_s);
        end else begin
            nxt = base | AW'(sum_s);
        end
    end
endmodule

// File: rtl/cbuf_bit_mirror.sv
// Full-width bit mirror, applied when en is set.
module cbuf_bit_mirror #(
    parameter int AW = 14
) (
    input  logic          en,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    logic [AW-1:0] flipped;

    for (genvar b = 0; b < AW; b++) begin : g_flip
        assign flipped[b] = din[AW-1-b];
    end

    assign dout = en ? flipped : din;
endmodule

// File: rtl/cbuf_dag.sv
module cbuf_dag #(
    parameter int AW    = 14,
    parameter int NSETS = 4,
    localparam int SW   = $clog2(NSETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_kind,
    input  logic [SW-1:0] wr_set,
    input  logic [AW-1:0] wr_data,
    input  logic          acc_en,
    input  logic [SW-1:0] acc_iset,
    input  logic [SW-1:0] acc_mset,
    input  logic          rev_mode,
    output logic [AW-1:0] addr_out
);
    import cbuf_pkg::*;

    typedef struct packed {
        logic [NSETS-1:0][AW-1:0] idx;
        logic [NSETS-1:0][AW-1:0] mod;
        logic [NSETS-1:0][AW-1:0] len;
    } dag_state_t;

    dag_state_t    st_d, st_q;
    logic [AW-1:0] idx_cur;
    logic [AW-1:0] mod_cur;
    logic [AW-1:0] len_cur;
    logic [AW-1:0] idx_next;

    assign idx_cur = st_q.idx[acc_iset];
    assign mod_cur = st_q.mod[acc_mset];
    assign len_cur = st_q.len[acc_iset];

    cbuf_wrap_step #(.AW(AW)) u_step (
        .idx (idx_cur),
        .mod (mod_cur),
        .len (len_cur),
        .nxt (idx_next)
    );

    cbuf_bit_mirror #(.AW(AW)) u_mirror (
        .en   (rev_mode),
        .din  (idx_cur),
        .dout (addr_out)
    );

    always_comb begin
        st_d = st_q;
        if (acc_en) begin
            st_d.idx[acc_iset] = idx_next;
        end
        // Writes are applied last so they win over the post-modify.
        if (wr_en) begin
            unique case (reg_kind_e'(wr_kind))
                KIND_INDEX:  st_d.idx[wr_set] = wr_data;
                KIND_MODIFY: st_d.mod[wr_set] = wr_data;
                KIND_LENGTH: st_d.len[wr_set] = wr_data;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cbuf_dag_chk.sv
module cbuf_dag_chk #(
    parameter int AW = 14,
    parameter int SW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_kind,
    input logic [SW-1:0] wr_set,
    input logic [AW-1:0] wr_data,
    input logic          acc_en,
    input logic [SW-1:0] acc_iset,
    input logic          rev_mode,
    input logic [AW-1:0] addr_out,
    input logic [AW-1:0] idx_cur,
    input logic [AW-1:0] mod_cur,
    input logic [AW-1:0] len_cur
);
    function automatic logic [AW-1:0] mirror_f(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int k = 0; k < AW; k++) r[k] = v[AW-1-k];
        return r;
    endfunction

    function automatic logic [AW-1:0] span_f(input logic [AW-1:0] l);
        logic [AW:0]   p;
        logic [AW-1:0] m;
        p = 1;
        m = '0;
        for (int k = 0; k < AW; k++) begin
            if (p < {1'b0, l}) begin
                m = AW'((p << 1) - 1);
                p = p << 1;
            end
        end
        return m;
    endfunction

    logic [AW-1:0] mk;
    logic [AW-1:0] mag;
    logic          in_ok;

    always_comb begin
        mk    = span_f(len_cur);
        mag   = mod_cur[AW-1] ? (~mod_cur + 1'b1) : mod_cur;
        in_ok = (len_cur != '0) && ((idx_cur & mk) < len_cur) && (mag <= len_cur);
    end

    // R2: plain output follows the selected index
    p_out_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rev_mode |-> addr_out == idx_cur);

    // R3: a circular update stays inside its buffer
    p_wrap_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !wr_en && in_ok) |=>
        (acc_iset != $past(acc_iset) || rev_mode ||
         (((addr_out & ~$past(mk)) == ($past(idx_cur) & ~$past(mk))) &&
          ((addr_out & $past(mk)) < $past(len_cur)))));

    // R5: zero length gives a linear step
    p_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !wr_en && len_cur == '0) |=>
        (acc_iset != $past(acc_iset) || rev_mode ||
         addr_out == AW'($past(idx_cur) + $past(mod_cur))));

    // R7: toggling reverse with no update mirrors the output only
    p_mirror_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !wr_en) |=>
        (acc_iset != $past(acc_iset) || rev_mode == $past(rev_mode) ||
         addr_out == mirror_f($past(addr_out))));

    // R9: a same-set index write beats the access update
    p_wr_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && wr_en && wr_kind == 2'b00 && wr_set == acc_iset) |=>
        (acc_iset != $past(acc_iset) || rev_mode || addr_out == $past(wr_data)));

    // R10: idle cycles hold the index
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !wr_en) |=>
        (acc_iset != $past(acc_iset) || rev_mode != $past(rev_mode) ||
         addr_out == $past(addr_out)));
endmodule

bind cbuf_dag cbuf_dag_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_kind  (wr_kind),
    .wr_set   (wr_set),
    .wr_data  (wr_data),
    .acc_en   (acc_en),
    .acc_iset (acc_iset),
    .rev_mode (rev_mode),
    .addr_out (addr_out),
    .idx_cur  (idx_cur),
    .mod_cur  (mod_cur),
    .len_cur  (len_cur)
);

// File: tb/sim_cbuf_dag.sv
`timescale 1ns/1ps
module sim_cbuf_dag;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'b00;
    logic [1:0]  wr_set = 2'b00;
    logic [13:0] wr_data = '0;
    logic        acc_en = 1'b0;
    logic [1:0]  acc_iset = 2'b00;
    logic [1:0]  acc_mset = 2'b00;
    logic        rev_mode = 1'b0;
    logic [13:0] addr_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cbuf_dag u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_set(wr_set), .wr_data(wr_data), .acc_en(acc_en),
        .acc_iset(acc_iset), .acc_mset(acc_mset), .rev_mode(rev_mode),
        .addr_out(addr_out)
    );

    function automatic logic [13:0] mir(input logic [13:0] v);
        logic [13:0] r;
        for (int k = 0; k < 14; k++) r[k] = v[13-k];
        return r;
    endfunction

    task automatic check(input logic [13:0] act, input logic [13:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One write cycle (starts and ends at a falling edge).
    task automatic wr(input logic [1:0] kind, input logic [1:0] set, input logic [13:0] d);
        wr_en = 1'b1; wr_kind = kind; wr_set = set; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One access cycle; the output is checked before the rising edge.
    task automatic acc(input logic [1:0] is, input logic [1:0] ms, input logic [13:0] exp, input string tag);
        acc_en = 1'b1; acc_iset = is; acc_mset = ms;
        #1 check(addr_out, exp, tag);
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] is, input logic [13:0] exp, input string tag);
        acc_en = 1'b0; acc_iset = is;
        #1 check(addr_out, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 4; s++) peek(2'(s), 14'h0000, "R1 index reset");
        acc(2'd2, 2'd3, 14'h0000, "R1 access after reset");
        peek(2'd2, 14'h0000, "R1 zero modify/length after reset");

        // R3 example: L=3 M=1 from 5
        wr(2'd2, 2'd0, 14'd3); wr(2'd1, 2'd0, 14'd1); wr(2'd0, 2'd0, 14'd5);
        acc(0, 0, 14'd5, "R3 seq a0"); acc(0, 0, 14'd6, "R3 seq a1");
        acc(0, 0, 14'd4, "R3 seq a2"); acc(0, 0, 14'd5, "R3 seq a3");
        // R4: M = -1 encoded 0x3FFF
        wr(2'd1, 2'd0, 14'h3FFF); wr(2'd0, 2'd0, 14'd5);
        acc(0, 0, 14'd5, "R4 neg a0"); acc(0, 0, 14'd4, "R4 neg a1");
        acc(0, 0, 14'd6, "R4 neg a2"); acc(0, 0, 14'd5, "R4 neg a3");
        // R3 example: L=5 M=3 from 9 (no direct hit on the boundary)
        wr(2'd2, 2'd0, 14'd5); wr(2'd1, 2'd0, 14'd3); wr(2'd0, 2'd0, 14'd9);
        acc(0, 0, 14'd9,  "R3 skip b0"); acc(0, 0, 14'd12, "R3 skip b1");
        acc(0, 0, 14'd10, "R3 skip b2"); acc(0, 0, 14'd8,  "R3 skip b3");
        acc(0, 0, 14'd11, "R3 skip b4"); acc(0, 0, 14'd9,  "R3 skip b5");

        // R3/R4/R6: sweep length 1..16, step -L..L, every start offset.
        // Index and length in set 1, modify in set 2.
        for (int L = 1; L <= 16; L++) begin
            logic [13:0] base;
            base = 14'(32'h1000 + L * 32);
            wr(2'd2, 2'd1, 14'(L));
            for (int m = -L; m <= L; m++) begin
                wr(2'd1, 2'd2, 14'(m));
                for (int off = 0; off < L; off++) begin
                    int e;
                    e = ((off + m) % L + L) % L;
                    wr(2'd0, 2'd1, base + 14'(off));
                    acc(2'd1, 2'd2, base + 14'(off), "R6 sweep start");
                    peek(2'd1, base + 14'(e), m < 0 ? "R4 sweep next" : "R3 sweep next");
                end
            end
        end

        // R5: linear step with zero length, wraps mod 2^14
        wr(2'd2, 2'd3, 14'd0); wr(2'd1, 2'd3, 14'd3); wr(2'd0, 2'd3, 14'h3FFE);
        acc(3, 3, 14'h3FFE, "R5 linear a0"); acc(3, 3, 14'h0001, "R5 linear a1");
        acc(3, 3, 14'h0004, "R5 linear a2");

        // R7: reversed output, normal-order storage; M = 2^(14-3)
        wr(2'd1, 2'd3, 14'h0800); wr(2'd0, 2'd3, 14'h0000);
        rev_mode = 1'b1;
        for (int k = 0; k < 8; k++) begin
            acc(3, 3, mir(14'(k * 32'h800)), "R7 reversed sweep");
        end
        peek(3, 14'h0000, "R7 reversed wrapped");
        wr(2'd0, 2'd3, 14'h0001);
        peek(3, 14'h2000, "R7 mirror of bit0");
        acc(3, 3, 14'h2000, "R7 access mirrored");
        peek(3, mir(14'h0801), "R7 mirror after step");
        rev_mode = 1'b0;
        peek(3, 14'h0801, "R7 stored in normal order");
        for (int v = 1; v < 14'h3FFF; v = v * 3 + 1) begin
            wr(2'd0, 2'd3, 14'(v));
            rev_mode = 1'b1;
            peek(3, mir(14'(v)), "R7 mirror pattern");
            rev_mode = 1'b0;
        end

        // R8: kind 3 writes nothing; modify write goes to its set only
        wr(2'd0, 2'd0, 14'h0123);
        wr(2'd3, 2'd0, 14'h3ABC);
        peek(0, 14'h0123, "R8 kind 3 ignored");
        wr(2'd2, 2'd0, 14'd0); wr(2'd1, 2'd0, 14'd2);
        wr(2'd1, 2'd1, 14'd7);
        acc(0, 0, 14'h0123, "R8 access set0");
        peek(0, 14'h0125, "R8 modify of set0 intact");

        // R9: write and access on the same index register
        acc_en = 1'b1; acc_iset = 2'd0; acc_mset = 2'd0;
        wr(2'd0, 2'd0, 14'h0100);
        acc_en = 1'b0;
        peek(0, 14'h0100, "R9 write wins over update");
        // write to another set during an access: both land
        acc_en = 1'b1; acc_iset = 2'd0; acc_mset = 2'd0;
        wr(2'd0, 2'd2, 14'h0777);
        acc_en = 1'b0;
        peek(0, 14'h0102, "R9 access still updates");
        peek(2, 14'h0777, "R9 other set written");

        // R10: idle cycles hold
        repeat (5) @(negedge clk);
        peek(0, 14'h0102, "R10 idle hold set0");
        peek(2, 14'h0777, "R10 idle hold set2");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule